// File: doc/BRIEF.md
# Gamma Lookup Table with Streaming Loader

This block holds the gamma correction tables for a small set of display channels and applies them to pixels on their way to the output. Each channel owns three 256-entry tables of 8-bit values, one each for red, green and blue. All tables share one flat storage array. A channel's tables sit back to back in red, green, blue order, and the channels follow one another in index order. Software loads the tables through a narrow control port. It first writes a pointer value, which can carry an auto-increment flag. It then streams data words, and the block keeps only the upper byte of each word, so 16-bit gamma values can be written unchanged.

On the pixel side, every cycle may carry one RGB888 pixel tagged with a channel number. The three colour bytes index their own tables in parallel through read ports that are separate from the write port. The corrected pixel appears one cycle later. A per-channel enable selects correction. When the bit is clear, or the channel number names no channel, the pixel passes through unchanged with the same latency. After reset the block fills every table with the identity curve on its own, one entry per cycle, and raises a ready flag when that is done.

Top module: `gamma_lut_top`

## Requirements
- R1: After reset `lut_ready` is low. The block then writes every entry with its index within its 256-entry table. `lut_ready` rises about DEPTH cycles later, where DEPTH = NUM_CH×768, and stays high until the next reset.
- R2: Control writes made while `lut_ready` is low have no effect on the pointer or on the table contents.
- R3: A control write with `ctl_sel`=0 loads the pointer from `ctl_wdata[ADDR_W-1:0]` and the auto-increment flag from `ctl_wdata[15]`. A pointer value of DEPTH or more loads 0 instead.
- R4: A control write with `ctl_sel`=1 stores `ctl_wdata[15:8]` at the entry the pointer selects. `ctl_wdata[7:0]` is discarded.
- R5: With the auto-increment flag set, each data write moves the pointer up by one. From DEPTH-1 it moves to 0.
- R6: With the auto-increment flag clear, data writes leave the pointer unchanged, so repeated writes overwrite the same entry.
- R7: The entry for channel c, component k (red 0, green 1, blue 2) and index i sits at c×768 + k×256 + i.
- R8: `out_valid` equals `pix_valid` delayed by exactly one cycle. `out_rgb` belongs to the pixel presented in the previous cycle.
- R9: When `gamma_en[pix_ch]` is set, each output byte is the table entry of that channel and component, indexed by the matching input byte. Red is in bits [23:16], green in [15:8] and blue in [7:0].
- R10: When the channel's enable bit is clear, or `pix_ch` ≥ NUM_CH, `out_rgb` equals the input pixel.
- R11: Pixel lookups are never held up by table writes. A lookup in the same cycle as a write to the same entry returns the old value. A lookup in the following cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_sel | input | 1 | 0 selects the pointer register, 1 selects the data register |
| ctl_wdata | input | 16 | Control write data |
| gamma_en | input | NUM_CH | Per-channel correction enable |
| pix_valid | input | 1 | Input pixel valid |
| pix_ch | input | CH_W | Channel of the input pixel |
| pix_rgb | input | 24 | Input pixel, R in [23:16], G in [15:8], B in [7:0] |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Corrected or passed-through pixel |
| lut_ready | output | 1 | Identity fill finished; control writes accepted |

## Verification
The bound checker checks the following on every cycle:
- the one-cycle valid delay;
- passthrough for disabled or unknown channels;
- pointer loading, stepping, wrap and holding;
- the pointer staying idle during the fill;
- `lut_ready` staying high once set.

Only the bench's scenarios can show the stored data. That covers identity after the fill, channel and component placement of a streamed table, upper-byte capture, overwrites without auto-increment, and read-before-write on a collision. The bench compares pixel outputs against its own model of the table.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
   localparam int COMPS       = 3;
   localparam int ENTRY_W     = 8;
   localparam int ENTRIES     = 256;
   localparam int RGB_W       = COMPS * ENTRY_W;
   localparam int CTL_W       = 16;
   localparam int AUTOINC_BIT = 15;
   localparam int CH_SPAN     = COMPS * ENTRIES;

   typedef enum logic {
      SEL_PTR  = 1'b0,
      SEL_DATA = 1'b1
   } ctl_sel_e;
endpackage

// File: rtl/gamma_wr_ctrl.sv
module gamma_wr_ctrl
   import gamma_lut_pkg::*;
#(
   parameter int DEPTH  = 1536,
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic              ctl_sel,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ENTRY_W-1:0] wr_data,
   output logic [ADDR_W-1:0] ptr,
   output logic              inc,
   output logic              ready
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   logic [ADDR_W-1:0] fill_q, ptr_q;
   logic              inc_q, ready_q;
   logic [ADDR_W-1:0] load_val;

   assign load_val = ctl_wdata[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_q  <= '0;
         ptr_q   <= '0;
         inc_q   <= 1'b0;
         ready_q <= 1'b0;
      end else if (!ready_q) begin
         fill_q <= fill_q + 1'b1;
         if (fill_q == LAST) ready_q <= 1'b1;
      end else if (ctl_we) begin
         if (ctl_sel == SEL_PTR) begin
            ptr_q <= (load_val <= LAST) ? load_val : '0;
            inc_q <= ctl_wdata[AUTOINC_BIT];
         end else if (inc_q) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
         end
      end
   end

   always_comb begin
      if (ready_q) begin
         wr_en   = ctl_we && (ctl_sel == SEL_DATA);
         wr_addr = ptr_q;
         wr_data = ctl_wdata[CTL_W-1 -: ENTRY_W];
      end else begin
         wr_en   = 1'b1;
         wr_addr = fill_q;
         wr_data = fill_q[ENTRY_W-1:0];
      end
   end

   assign ptr   = ptr_q;
   assign inc   = inc_q;
   assign ready = ready_q;
endmodule

// File: rtl/gamma_lut_mem.sv
module gamma_lut_mem #(
   parameter int DEPTH    = 1536,
   parameter int ADDR_W   = 11,
   parameter int W        = 8,
   parameter int RD_PORTS = 3
) (
   input  logic                              clk,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [W-1:0]                      wr_data,
   input  logic [RD_PORTS-1:0][ADDR_W-1:0]   rd_addr,
   output logic [RD_PORTS-1:0][W-1:0]        rd_data
);
   logic [W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      always_ff @(posedge clk) begin
         rd_data[p] <= store[rd_addr[p]];
      end
   end
endmodule

// File: rtl/gamma_pix_path.sv
module gamma_pix_path
   import gamma_lut_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int CH_W   = 2,
   parameter int ADDR_W = 11
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             pix_valid,
   input  logic [CH_W-1:0]                  pix_ch,
   input  logic [RGB_W-1:0]                 pix_rgb,
   input  logic [NUM_CH-1:0]                gamma_en,
   output logic [COMPS-1:0][ADDR_W-1:0]     rd_addr,
   input  logic [COMPS-1:0][ENTRY_W-1:0]    rd_data,
   output logic                             out_valid,
   output logic [RGB_W-1:0]                 out_rgb
);
   localparam int EXT = 2 ** CH_W;

   logic [EXT-1:0]    en_ext;
   logic              use_lut;
   logic [ADDR_W-1:0] base;
   logic              valid_q, lut_q;
   logic [RGB_W-1:0]  raw_q;

   always_comb begin
      en_ext = '0;
      en_ext[NUM_CH-1:0] = gamma_en;
      use_lut = en_ext[pix_ch];
      base = use_lut ? ADDR_W'(pix_ch) * ADDR_W'(CH_SPAN) : '0;
   end

   for (genvar k = 0; k < COMPS; k++) begin : g_addr
      assign rd_addr[k] = base + ADDR_W'(k * ENTRIES)
                        + ADDR_W'(pix_rgb[RGB_W-1-k*ENTRY_W -: ENTRY_W]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         lut_q   <= 1'b0;
         raw_q   <= '0;
      end else begin
         valid_q <= pix_valid;
         lut_q   <= use_lut;
         raw_q   <= pix_rgb;
      end
   end

   assign out_valid = valid_q;
   assign out_rgb   = lut_q ? {rd_data[0], rd_data[1], rd_data[2]} : raw_q;
endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top
   import gamma_lut_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int CH_W   = $clog2(NUM_CH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic              ctl_sel,
   input  logic [CTL_W-1:0]  ctl_wdata,
   input  logic [NUM_CH-1:0] gamma_en,
   input  logic              pix_valid,
   input  logic [CH_W-1:0]   pix_ch,
   input  logic [RGB_W-1:0]  pix_rgb,
   output logic              out_valid,
   output logic [RGB_W-1:0]  out_rgb,
   output logic              lut_ready
);
   localparam int DEPTH  = NUM_CH * CH_SPAN;
   localparam int ADDR_W = $clog2(DEPTH);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (ADDR_W > AUTOINC_BIT) begin : g_bad_addr
      $error("pointer field overlaps the auto-increment flag");
   end
   if ((2 ** CH_W) < NUM_CH) begin : g_bad_chw
      $error("CH_W too narrow for NUM_CH");
   end

   logic                          wr_en;
   logic [ADDR_W-1:0]             wr_addr;
   logic [ENTRY_W-1:0]            wr_data;
   logic [ADDR_W-1:0]             wr_ptr;
   logic                          wr_inc;
   logic [COMPS-1:0][ADDR_W-1:0]  rd_addr;
   logic [COMPS-1:0][ENTRY_W-1:0] rd_data;

   gamma_wr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
      .ctl_wdata(ctl_wdata), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ptr(wr_ptr), .inc(wr_inc), .ready(lut_ready)
   );

   gamma_lut_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .W(ENTRY_W), .RD_PORTS(COMPS)) u_mem (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   gamma_pix_path #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_pix (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ch(pix_ch),
      .pix_rgb(pix_rgb), .gamma_en(gamma_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .out_valid(out_valid), .out_rgb(out_rgb)
   );
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk
   import gamma_lut_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int CH_W   = 2,
   parameter int DEPTH  = 1536,
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ctl_we,
   input logic              ctl_sel,
   input logic [CTL_W-1:0]  ctl_wdata,
   input logic [NUM_CH-1:0] gamma_en,
   input logic              pix_valid,
   input logic [CH_W-1:0]   pix_ch,
   input logic [RGB_W-1:0]  pix_rgb,
   input logic              out_valid,
   input logic [RGB_W-1:0]  out_rgb,
   input logic              lut_ready,
   input logic [ADDR_W-1:0] wr_ptr,
   input logic              wr_inc
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   logic [(2**CH_W)-1:0] en_ext;
   logic                 en_bit;
   logic [ADDR_W-1:0]    field;
   logic                 data_wr, ptr_wr;

   always_comb begin
      en_ext = '0;
      en_ext[NUM_CH-1:0] = gamma_en;
      en_bit  = en_ext[pix_ch];
      field   = ctl_wdata[ADDR_W-1:0];
      data_wr = lut_ready && ctl_we && ctl_sel;
      ptr_wr  = lut_ready && ctl_we && !ctl_sel;
   end

   a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lut_ready |=> lut_ready);
   a_r2_ptr_idle_fill: assert property (@(posedge clk) disable iff (!rst_n)
      !lut_ready |-> wr_ptr == '0);
   a_r3_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_wr && field <= LAST) |=> wr_ptr == $past(field));
   a_r3_ptr_load_oor: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_wr && field > LAST) |=> wr_ptr == '0);
   a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && wr_inc && wr_ptr != LAST) |=> wr_ptr == $past(wr_ptr) + 1'b1);
   a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && wr_inc && wr_ptr == LAST) |=> wr_ptr == '0);
   a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !wr_inc) |=> $stable(wr_ptr));
   a_r8_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |=> out_valid);
   a_r8_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |=> !out_valid);
   a_r10_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !en_bit) |=> out_rgb == $past(pix_rgb));
endmodule

bind gamma_lut_top gamma_lut_chk #(
   .NUM_CH(NUM_CH), .CH_W(CH_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
   .ctl_wdata(ctl_wdata), .gamma_en(gamma_en), .pix_valid(pix_valid),
   .pix_ch(pix_ch), .pix_rgb(pix_rgb), .out_valid(out_valid),
   .out_rgb(out_rgb), .lut_ready(lut_ready), .wr_ptr(wr_ptr), .wr_inc(wr_inc)
);

// File: tb/gamma_lut_top_tb_top.sv
`timescale 1ns/1ps
module gamma_lut_top_tb_top;
   localparam int NUM_CH = 2;
   localparam int CH_W   = 2;
   localparam int DEPTH  = NUM_CH * 768;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic        ctl_sel = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic [NUM_CH-1:0] gamma_en = '0;
   logic        pix_valid = 1'b0;
   logic [CH_W-1:0] pix_ch = '0;
   logic [23:0] pix_rgb = '0;
   logic        out_valid;
   logic [23:0] out_rgb;
   logic        lut_ready;

   int checks = 0;
   int errors = 0;
   logic [7:0] model [DEPTH];
   int  m_ptr = 0;
   bit  m_inc = 1'b0;

   always #2.5 clk = ~clk;

   gamma_lut_top #(.NUM_CH(NUM_CH), .CH_W(CH_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
      .ctl_wdata(ctl_wdata), .gamma_en(gamma_en), .pix_valid(pix_valid),
      .pix_ch(pix_ch), .pix_rgb(pix_rgb), .out_valid(out_valid),
      .out_rgb(out_rgb), .lut_ready(lut_ready)
   );

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [23:0] exp_px(int ch, logic [23:0] rgb);
      if (ch < NUM_CH && gamma_en[ch])
         return {model[ch*768 + rgb[23:16]], model[ch*768 + 256 + rgb[15:8]],
                 model[ch*768 + 512 + rgb[7:0]]};
      return rgb;
   endfunction

   task automatic model_write(bit sel, logic [15:0] d);
      if (!sel) begin
         m_ptr = (d[10:0] < DEPTH) ? int'(d[10:0]) : 0;
         m_inc = d[15];
      end else begin
         model[m_ptr] = d[15:8];
         if (m_inc) m_ptr = (m_ptr + 1) % DEPTH;
      end
   endtask

   task automatic ctl_write(bit sel, logic [15:0] d, bit track);
      ctl_we = 1'b1; ctl_sel = sel; ctl_wdata = d;
      @(negedge clk);
      ctl_we = 1'b0;
      if (track) model_write(sel, d);
   endtask

   task automatic px_check(int ch, logic [23:0] rgb, string req);
      logic [23:0] e;
      e = exp_px(ch, rgb);
      pix_valid = 1'b1; pix_ch = CH_W'(ch); pix_rgb = rgb;
      @(negedge clk);
      pix_valid = 1'b0;
      chk(out_valid == 1'b1, req, "out_valid", int'(out_valid), 1);
      chk(out_rgb == e, req, "out_rgb", int'(out_rgb), int'(e));
   endtask

   task automatic t_reset_fill();
      int cyc = 0;
      for (int i = 0; i < DEPTH; i++) model[i] = 8'(i);
      repeat (3) @(negedge clk);
      chk(lut_ready == 1'b0, "R1", "ready in reset", int'(lut_ready), 0);
      chk(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      // R2: these writes land during the fill and must be dropped
      ctl_write(1'b0, 16'h8005, 1'b0); cyc++;
      ctl_write(1'b1, 16'hAB00, 1'b0); cyc++;
      while (!lut_ready && cyc < DEPTH + 10) begin
         @(negedge clk); cyc++;
      end
      chk(lut_ready == 1'b1, "R1", "ready rose", int'(lut_ready), 1);
      chk(cyc >= DEPTH - 2 && cyc <= DEPTH + 2, "R1", "fill cycles", cyc, DEPTH);
   endtask

   task automatic t_identity();
      gamma_en = '1;
      px_check(0, 24'h05_80_FF, "R2");
      px_check(1, 24'h00_7F_13, "R1");
   endtask

   task automatic t_stream();
      ctl_write(1'b0, 16'h8000 | 16'(768), 1'b1);
      for (int i = 0; i < 768; i++)
         ctl_write(1'b1, {8'((i * 7 + 3) & 8'hFF), 8'h5A}, 1'b1);
      px_check(1, 24'h00_00_00, "R7");
      px_check(1, 24'h10_FF_3C, "R9");
      px_check(0, 24'h10_FF_3C, "R4");
   endtask

   task automatic t_noinc();
      ctl_write(1'b0, 16'd10, 1'b1);
      ctl_write(1'b1, 16'h1100, 1'b1);
      ctl_write(1'b1, 16'h2200, 1'b1);
      px_check(0, 24'h0A_0B_00, "R6");
   endtask

   task automatic t_wrap();
      ctl_write(1'b0, 16'h8000 | 16'(DEPTH - 1), 1'b1);
      ctl_write(1'b1, 16'h7700, 1'b1);
      ctl_write(1'b1, 16'h8800, 1'b1);
      px_check(NUM_CH - 1, 24'h00_00_FF, "R5");
      px_check(0, 24'h00_00_00, "R5");
      ctl_write(1'b0, 16'h8000 | 16'(DEPTH + 3), 1'b1);
      ctl_write(1'b1, 16'h3300, 1'b1);
      px_check(0, 24'h00_01_02, "R3");
   endtask

   task automatic t_bypass();
      gamma_en = 2'b01;
      px_check(1, 24'h10_FF_3C, "R10");
      gamma_en = '1;
      px_check(3, 24'h12_34_56, "R10");
      px_check(2, 24'hAB_CD_EF, "R10");
   endtask

   task automatic t_latency();
      pix_valid = 1'b1; pix_ch = 0; pix_rgb = 24'h01_02_03;
      @(negedge clk);
      pix_rgb = 24'h04_05_06;
      chk(out_valid == 1'b1, "R8", "first valid", int'(out_valid), 1);
      chk(out_rgb == exp_px(0, 24'h01_02_03), "R8", "first pixel", int'(out_rgb),
          int'(exp_px(0, 24'h01_02_03)));
      @(negedge clk);
      pix_valid = 1'b0;
      chk(out_rgb == exp_px(0, 24'h04_05_06), "R8", "second pixel", int'(out_rgb),
          int'(exp_px(0, 24'h04_05_06)));
      @(negedge clk);
      chk(out_valid == 1'b0, "R8", "valid drop", int'(out_valid), 0);
   endtask

   task automatic t_collide();
      logic [23:0] e_old;
      ctl_write(1'b0, 16'd20, 1'b1);
      e_old = exp_px(0, 24'h14_00_00);
      ctl_we = 1'b1; ctl_sel = 1'b1; ctl_wdata = 16'h5500;
      pix_valid = 1'b1; pix_ch = 0; pix_rgb = 24'h14_00_00;
      @(negedge clk);
      ctl_we = 1'b0; pix_valid = 1'b0;
      chk(out_rgb == e_old, "R11", "same-cycle read", int'(out_rgb), int'(e_old));
      model_write(1'b1, 16'h5500);
      px_check(0, 24'h14_00_00, "R11");
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset_fill();
      t_identity();
      t_stream();
      t_noinc();
      t_wrap();
      t_bypass();
      t_latency();
      t_collide();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule